// File: doc/BRIEF.md
# Sine Tone Synthesiser with Serial DAC Load Strobe

This block generates a fixed 2 kHz sine tone for a 12-bit serial DAC. It runs from a 64 MHz system clock. A free-running sample timer ticks every 2000 cycles, which gives a 32 kHz sample rate. On every tick the block reads the current point from a 16-entry sine table and advances a 4-bit phase index. It places the 12-bit sample in a 16-bit command word and shifts that word to the DAC over a mode-0 SPI link, framed by an active-low chip select.

After the frame ends, the block waits a fixed number of cycles. It then pulls an active-low load strobe low for 64 cycles (1 µs), and this strobe transfers the new sample to the DAC output. All output timing is referenced to the sample timer, so each strobe falls at the same offset from its tick. Consecutive strobes are therefore exactly one sample period apart.

The table holds offset-binary codes round(2047.5 + 2047.5·sin(2πk/16)) for k = 0..15. Entry 0 is 2048, entry 4 is 4095 and entry 12 is 0. Sixteen samples make one period of the tone.

Top module: `sine_dds_dac`

## Requirements
- R1: While reset (`rst`, active high, synchronous) is applied, and after it is released until the first sample tick, `dac_cs_n` and `dac_load_n` are 1 and `dac_sclk` is 0.
- R2: Consecutive falling edges of `dac_load_n` are exactly SAMPLE_DIV (2000) clock cycles apart.
- R3: Each frame carries 16 bits, most significant bit first. `dac_cs_n` stays low for the whole frame and `dac_sclk` gives exactly 16 rising edges while it is low. `dac_mosi` is sampled on the rising edge of `dac_sclk`, and `dac_sclk` is 0 whenever `dac_cs_n` is 1.
- R4: `dac_load_n` stays low for exactly STROBE_LEN (64) clock cycles in each sample period.
- R5: `dac_load_n` falls exactly STROBE_GAP (8) cycles after `dac_cs_n` rises, and `dac_cs_n` is 1 throughout the strobe.
- R6: Bits [11:0] of frame n after reset carry table entry n mod 16. Entry k is round(2047.5 + 2047.5·sin(2πk/16)). The phase index steps by one, modulo 16, on every tick.
- R7: Bits [15:12] of every frame are, from the top down: channel select 0, buffer select 0, gain select 0 and active (not shut down) 1. Read as a hex nibble, the field is 0x1.
- R8: `dac_cs_n` is low for exactly 32·SPI_HALF (128) cycles per frame, and the frame always completes before the next tick.
- R9: A reset applied partway through a frame returns all outputs to idle. The first frame after release carries table entry 0 (2048), and the second carries entry 1 (2831).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (64 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| dac_sclk | output | 1 | Serial clock to the DAC, idle low |
| dac_mosi | output | 1 | Serial data to the DAC, MSB first |
| dac_cs_n | output | 1 | Frame select, active low |
| dac_load_n | output | 1 | DAC output load strobe, active low |

## Verification
The bench decodes every frame at the pins and compares it with sine values it computes itself. A phase index that did not wrap, or a table lookup taken after the increment, would show up as a wrong value or one shifted by a single table entry. The bench measures strobe width, strobe spacing and the gap from frame end to strobe in cycles. This catches a counter that is off by one, which would give 63 or 65 low cycles, 1999 or 2001 between strobes, or a gap of 7 or 9. A reset issued partway through a frame checks that a stale shift register or phase value does not leak into the restart. Checking the control nibble on every frame catches swapped gain and shutdown bits.

// File: rtl/sine_dds_pkg.sv
package sine_dds_pkg;

  localparam int CODE_W = 12;
  localparam int CMD_W  = 16;
  localparam int IDX_W  = 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // Command word layout, MSB first
  typedef struct packed {
    logic  chan_b;     // 0: channel A
    logic  buffered;   // 0: unbuffered reference
    logic  gain_sel;   // held at 0
    logic  active;     // 1: output enabled
    code_t code;
  } dac_cmd_s;

  localparam logic CHAN_SEL = 1'b0;
  localparam logic BUF_SEL  = 1'b0;
  localparam logic GAIN_SEL = 1'b0;
  localparam logic RUN_SEL  = 1'b1;

  // One period of offset-binary sine, 16 points
  function automatic code_t sine_code(input idx_t k);
    case (k)
      4'd0:    sine_code = 12'd2048;
      4'd1:    sine_code = 12'd2831;
      4'd2:    sine_code = 12'd3495;
      4'd3:    sine_code = 12'd3939;
      4'd4:    sine_code = 12'd4095;
      4'd5:    sine_code = 12'd3939;
      4'd6:    sine_code = 12'd3495;
      4'd7:    sine_code = 12'd2831;
      4'd8:    sine_code = 12'd2048;
      4'd9:    sine_code = 12'd1264;
      4'd10:   sine_code = 12'd600;
      4'd11:   sine_code = 12'd156;
      4'd12:   sine_code = 12'd0;
      4'd13:   sine_code = 12'd156;
      4'd14:   sine_code = 12'd600;
      default: sine_code = 12'd1264;
    endcase
  endfunction

  function automatic cmd_t make_cmd(input code_t c);
    dac_cmd_s w;
    w.chan_b   = CHAN_SEL;
    w.buffered = BUF_SEL;
    w.gain_sel = GAIN_SEL;
    w.active   = RUN_SEL;
    w.code     = c;
    return cmd_t'(w);
  endfunction

endpackage

// File: rtl/dds_sample_timer.sv
module dds_sample_timer #(
  parameter int SAMPLE_DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(SAMPLE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dds_phase_table.sv
module dds_phase_table
  import sine_dds_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  output idx_t  idx,
  output code_t code
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end

  assign code = sine_code(idx);
endmodule

// File: rtl/dds_spi_shifter.sv
module dds_spi_shifter #(
  parameter int SPI_HALF = 4,
  parameter int BITS     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] word,
  output logic            sclk,
  output logic            mosi,
  output logic            cs_n,
  output logic            busy,
  output logic            done
);
  localparam int DW = (SPI_HALF > 1) ? $clog2(SPI_HALF) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0] sh;
  logic [DW-1:0]   div;
  logic [BW-1:0]   nbit;
  logic            edge_due;
  logic            last_bit;

  assign edge_due = (div == DW'(SPI_HALF - 1));
  assign last_bit = (nbit == BW'(BITS - 1));
  assign mosi     = cs_n ? 1'b0 : sh[BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      div  <= '0;
      nbit <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cs_n <= 1'b0;
          sh   <= word;
          div  <= '0;
          nbit <= '0;
          sclk <= 1'b0;
        end
      end else if (edge_due) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (last_bit) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            nbit <= nbit + 1'b1;
            sh   <= {sh[BITS-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dds_load_strobe.sv
module dds_load_strobe #(
  parameter int STROBE_GAP = 8,
  parameter int STROBE_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic load_n
);
  localparam int MAXV = (STROBE_GAP > STROBE_LEN) ? STROBE_GAP : STROBE_LEN;
  localparam int CW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_LOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      load_n <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (trigger) begin
          if (STROBE_GAP <= 1) begin
            st     <= ST_LOW;
            load_n <= 1'b0;
            cnt    <= '0;
          end else begin
            st  <= ST_WAIT;
            cnt <= CW'(1);
          end
        end
        ST_WAIT: begin
          if (cnt == CW'(STROBE_GAP - 1)) begin
            st     <= ST_LOW;
            load_n <= 1'b0;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt == CW'(STROBE_LEN - 1)) begin
            st     <= ST_IDLE;
            load_n <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sine_dds_dac.sv
module sine_dds_dac
  import sine_dds_pkg::*;
#(
  parameter int SAMPLE_DIV = 2000,
  parameter int SPI_HALF   = 4,
  parameter int STROBE_GAP = 8,
  parameter int STROBE_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  output logic dac_sclk,
  output logic dac_mosi,
  output logic dac_cs_n,
  output logic dac_load_n
);
  // Named internal events, visible to the bound checker
  logic  sample_tick;
  idx_t  phase_idx;
  code_t sample_code;
  cmd_t  cmd_word;
  logic  frame_busy;
  logic  frame_done;

  dds_sample_timer #(.SAMPLE_DIV(SAMPLE_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick)
  );

  dds_phase_table u_table (
    .clk  (clk),
    .rst  (rst),
    .step (sample_tick),
    .idx  (phase_idx),
    .code (sample_code)
  );

  assign cmd_word = make_cmd(sample_code);

  dds_spi_shifter #(.SPI_HALF(SPI_HALF), .BITS(CMD_W)) u_spi (
    .clk   (clk),
    .rst   (rst),
    .start (sample_tick),
    .word  (cmd_word),
    .sclk  (dac_sclk),
    .mosi  (dac_mosi),
    .cs_n  (dac_cs_n),
    .busy  (frame_busy),
    .done  (frame_done)
  );

  dds_load_strobe #(.STROBE_GAP(STROBE_GAP), .STROBE_LEN(STROBE_LEN)) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .trigger (frame_done),
    .load_n  (dac_load_n)
  );
endmodule

// File: rtl/sine_dds_dac_checks.sv
module sine_dds_dac_checks #(
  parameter int STROBE_LEN = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       sample_tick,
  input logic [3:0] phase_idx,
  input logic       frame_busy,
  input logic       dac_sclk,
  input logic       dac_cs_n,
  input logic       dac_load_n
);
  localparam int LW = $clog2(STROBE_LEN + 2);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)             low_run <= '0;
    else if (!dac_load_n) low_run <= low_run + 1'b1;
    else                 low_run <= '0;
  end

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_load_n) |-> (low_run == LW'(STROBE_LEN)));

  p_cs_idle_in_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !dac_load_n |-> dac_cs_n);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk);

  p_frame_opens_r3: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !dac_cs_n);

  p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> (phase_idx == $past(phase_idx) + 4'd1));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    sample_tick |-> (!frame_busy && dac_load_n));
endmodule

bind sine_dds_dac sine_dds_dac_checks #(.STROBE_LEN(STROBE_LEN)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .sample_tick (sample_tick),
  .phase_idx   (phase_idx),
  .frame_busy  (frame_busy),
  .dac_sclk    (dac_sclk),
  .dac_cs_n    (dac_cs_n),
  .dac_load_n  (dac_load_n)
);

// File: tb/sine_dds_dac_test.sv
`timescale 1ns/1ps
module sine_dds_dac_test;

  localparam int SAMPLE_DIV = 2000;
  localparam int SPI_HALF   = 4;
  localparam int STROBE_GAP = 8;
  localparam int STROBE_LEN = 64;
  localparam int MAXREC     = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dac_sclk, dac_mosi, dac_cs_n, dac_load_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sine_dds_dac #(
    .SAMPLE_DIV(SAMPLE_DIV), .SPI_HALF(SPI_HALF),
    .STROBE_GAP(STROBE_GAP), .STROBE_LEN(STROBE_LEN)
  ) uut (
    .clk(clk), .rst(rst),
    .dac_sclk(dac_sclk), .dac_mosi(dac_mosi),
    .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n)
  );

  // Pin-level monitor, sampled at the falling clock edge
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] fr_word  [MAXREC];
  int          fr_bits  [MAXREC];
  int          fr_len   [MAXREC];
  longint      fr_rise  [MAXREC];
  longint      ld_fall  [MAXREC];
  int          ld_len   [MAXREC];
  int nf = 0, nl = 0, cs_viol = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1;
  logic [15:0] sh_acc;
  int     nb;
  longint cs_fall_t;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_cs && !dac_cs_n) begin sh_acc = '0; nb = 0; cs_fall_t = cyc; end
      if (!p_sclk && dac_sclk && !dac_cs_n) begin sh_acc = {sh_acc[14:0], dac_mosi}; nb++; end
      if (!p_cs && dac_cs_n && nf < MAXREC) begin
        fr_word[nf] = sh_acc; fr_bits[nf] = nb;
        fr_len[nf] = int'(cyc - cs_fall_t); fr_rise[nf] = cyc; nf++;
      end
      if (p_ld && !dac_load_n && nl < MAXREC) ld_fall[nl] = cyc;
      if (!p_ld && dac_load_n && nl < MAXREC) begin ld_len[nl] = int'(cyc - ld_fall[nl]); nl++; end
      if (!dac_load_n && !dac_cs_n) cs_viol++;
    end
    p_sclk = dac_sclk; p_cs = dac_cs_n; p_ld = dac_load_n;
  end

  function automatic int ref_sine(input int k);
    real v;
    v = 2047.5 + 2047.5 * $sin(2.0 * 3.14159265358979 * real'(k % 16) / 16.0);
    return int'($floor(v + 0.5));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset_idle();
    // R1: idle outputs under reset and before first tick
    repeat (3) @(negedge clk);
    chk(dac_cs_n == 1'b1, "R1 cs_n in reset", dac_cs_n, 1);
    chk(dac_load_n == 1'b1, "R1 load_n in reset", dac_load_n, 1);
    chk(dac_sclk == 1'b0, "R1 sclk in reset", dac_sclk, 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(dac_cs_n && dac_load_n && !dac_sclk, "R1 idle before tick",
        {dac_cs_n, dac_load_n, dac_sclk}, 3'b110);
  endtask

  task automatic t_stream(input int n);
    int bad_data = 0, bad_ctl = 0, bad_bits = 0, bad_len = 0;
    int bad_w = 0, bad_gap = 0, bad_per = 0;
    while (nl < n) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (fr_word[i][11:0] != 12'(ref_sine(i))) begin
        bad_data++;
        chk(0, "R6 sample value", fr_word[i][11:0], ref_sine(i));
      end
      if (fr_word[i][15:12] != 4'h1) begin
        bad_ctl++;
        chk(0, "R7 control nibble", fr_word[i][15:12], 1);
      end
      if (fr_bits[i] != 16) bad_bits++;
      if (fr_len[i] != 32 * SPI_HALF) bad_len++;
      if (ld_len[i] != STROBE_LEN) bad_w++;
      if (ld_fall[i] - fr_rise[i] != STROBE_GAP) bad_gap++;
      if (i > 0 && ld_fall[i] - ld_fall[i-1] != SAMPLE_DIV) bad_per++;
    end
    chk(bad_data == 0, "R6 all samples", bad_data, 0);
    chk(bad_ctl == 0, "R7 all control fields", bad_ctl, 0);
    chk(fr_word[4][11:0] == 12'd4095, "R6 peak entry", fr_word[4][11:0], 4095);
    chk(fr_word[12][11:0] == 12'd0, "R6 trough entry", fr_word[12][11:0], 0);
    chk(fr_word[16][11:0] == 12'd2048, "R6 wrap to entry 0", fr_word[16][11:0], 2048);
    chk(bad_bits == 0, "R3 16 clocks per frame", fr_bits[0], 16);
    chk(bad_len == 0, "R8 frame length", fr_len[0], 32 * SPI_HALF);
    chk(bad_w == 0, "R4 strobe width", ld_len[0], STROBE_LEN);
    chk(bad_gap == 0, "R5 strobe gap", ld_fall[0] - fr_rise[0], STROBE_GAP);
    chk(bad_per == 0, "R2 strobe spacing", ld_fall[1] - ld_fall[0], SAMPLE_DIV);
    chk(cs_viol == 0, "R5 cs_n high during strobe", cs_viol, 0);
  endtask

  task automatic t_mid_reset();
    // R9: reset in the middle of a frame
    while (dac_cs_n) @(negedge clk);
    repeat (37) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(dac_cs_n && dac_load_n && !dac_sclk, "R9 idle under reset",
        {dac_cs_n, dac_load_n, dac_sclk}, 3'b110);
    nf = 0; nl = 0;
    rst = 1'b0;
    while (nl < 2) @(negedge clk);
    chk(fr_word[0][11:0] == 12'd2048, "R9 first sample after reset", fr_word[0][11:0], 2048);
    chk(fr_word[1][11:0] == 12'd2831, "R9 second sample after reset", fr_word[1][11:0], 2831);
    chk(fr_bits[0] == 16, "R9 clean first frame", fr_bits[0], 16);
  endtask

  initial begin
    t_reset_idle();
    t_stream(20);
    t_mid_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule